// File: doc/BRIEF.md
# Learned IR Pattern Matcher

This block decides whether an infrared packet that has just been captured is one of a few commands learned earlier. A packet is a list of elements, alternating marks and spaces. Each element is a 16-bit tick count stored as two bytes, low byte first. The capture buffer and the non-volatile pattern store are both outside the block. The block reaches each of them through a byte-wide synchronous read port, and it writes the store through a byte-wide write port.

When `cmp_req` arrives, the block scans the stored slots in turn, starting at slot 0. It compares one element per three clock cycles. It then reports the outcome with a single-cycle `done` strobe, together with `hit` and the slot index. A hit on slot 0 switches the output load on, or toggles it when `toggle_mode` is high. A hit on slot 1 switches the load off. A short button press toggles the load by hand.

A `learn_req` arms learning. The next `cmp_req` then copies the captured packet into the current learn slot instead of comparing it, and the learn slot moves on by one. After the last slot it returns to slot 0.

Top module: `irm_top`

## Requirements
- R1: After synchronous reset, `done`, `hit`, `hit_slot`, `pat_we` and `load_on` are low, learning is disarmed and the learn slot is 0.
- R2: On a `cmp_req` taken while idle, slots are scanned from slot 0 upward and the first matching slot wins. `done` rises for exactly one cycle, 3×T cycles after the request edge, where T is the total number of elements evaluated. `hit_slot` carries the matching slot when `hit` is high, and is 0 on a miss.
- R3: Element e of slot s uses the low byte at store address s×256+2e and the low byte at capture address 2e. The element passes when (stored − captured) mod 256 is ≤ 4 or ≥ 252. Captured high bytes have no effect.
- R4: If the stored high byte of an element (address s×256+2e+1) equals 2, the slot matches at that element. The low byte of that element is not compared.
- R5: If the stored high byte of an element equals 0xFF, the slot misses at that element.
- R6: A slot with no end marker misses after 128 elements have been evaluated.
- R7: On a hit, slot 0 sets the load to 1, or inverts it when `toggle_mode` is 1; slot 1 clears it. The load changes one cycle after `done`. Otherwise the load holds, except as stated in R10.
- R8: `learn_req` arms learning. The next `cmp_req` with `cap_len` = L > 0 copies capture bytes 0..4L−1 to store addresses slot×256+i and raises no `done`. The learn slot then advances, going from the last slot back to 0.
- R9: A `cmp_req` that is armed with `cap_len` = 0 writes nothing, leaves the learn slot unchanged and disarms learning. A later `cmp_req` performs a normal compare.
- R10: `btn_short` high for one cycle inverts the load at the next clock edge.
- R11: `cmp_req` and `learn_req` have no effect while a compare or a copy is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_req | input | 1 | Packet ready: compare it, or store it if learning is armed |
| learn_req | input | 1 | Arm learning for the next packet |
| cap_len | input | 7 | Number of mark/space pairs in the captured packet |
| toggle_mode | input | 1 | 1: a slot 0 hit inverts the load |
| btn_short | input | 1 | Short button press, inverts the load |
| cap_addr | output | 8 | Capture buffer byte address |
| cap_rdata | input | 8 | Capture read data, one cycle after address |
| pat_addr | output | 9 | Pattern store byte address |
| pat_we | output | 1 | Pattern store write enable |
| pat_wdata | output | 8 | Pattern store write data |
| pat_rdata | input | 8 | Pattern store read data, one cycle after address |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A slot matched (valid with `done`) |
| hit_slot | output | 1 | Index of the matching slot |
| load_on | output | 1 | Output load state |

## Verification
A wrong element counter or slot register shows at the ports as a `done` strobe that comes early or late by a multiple of three cycles, or as the wrong `hit_slot`. Either one is visible within the same compare. A corrupted learn-slot pointer shows at the next learn, because the bytes land in the wrong region of the external store. A latched arm flag that fails to clear turns the following compare into a copy, so its `done` never arrives. A fault in the load register shows one cycle after the `done` or the button press that should have moved it.

// File: rtl/irm_pkg.sv
`timescale 1ns/1ps
package irm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_EVAL,
        ST_CP_RD,
        ST_CP_WR
    } seq_state_e;

    typedef enum logic [1:0] {
        EV_NEXT,
        EV_MATCH,
        EV_FAIL
    } elem_verdict_e;

    // Circular distance of the low bytes: true when within +/-tol ticks.
    function automatic logic lo_in_window(input logic [7:0] stored,
                                          input logic [7:0] seen,
                                          input int unsigned tol);
        logic [7:0] d;
        d = stored - seen;
        return (32'(d) <= tol) || ((32'(d) + tol) >= 32'd256);
    endfunction

endpackage

// File: rtl/irm_tol_cmp.sv
`timescale 1ns/1ps
module irm_tol_cmp
    import irm_pkg::*;
#(
    parameter int unsigned TOL = 4
) (
    input  logic [7:0] stored,
    input  logic [7:0] seen,
    output logic       ok
);
    generate
        if (TOL == 0) begin : g_exact
            assign ok = (stored == seen);
        end else begin : g_window
            assign ok = lo_in_window(stored, seen, TOL);
        end
    endgenerate
endmodule

// File: rtl/irm_elem_judge.sv
`timescale 1ns/1ps
module irm_elem_judge
    import irm_pkg::*;
#(
    parameter logic [7:0] END_MARK    = 8'h02,
    parameter logic [7:0] ERASED_MARK = 8'hFF
) (
    input  logic [7:0]    hi_byte,
    input  logic          lo_ok,
    input  logic          last_elem,
    output elem_verdict_e verdict
);
    always_comb begin
        if (hi_byte == ERASED_MARK) begin
            verdict = EV_FAIL;
        end else if (hi_byte == END_MARK) begin
            verdict = EV_MATCH;
        end else if (!lo_ok || last_elem) begin
            verdict = EV_FAIL;
        end else begin
            verdict = EV_NEXT;
        end
    end
endmodule

// File: rtl/irm_load_ctl.sv
`timescale 1ns/1ps
module irm_load_ctl #(
    parameter int SLOT_W   = 1,
    parameter int ON_SLOT  = 0,
    parameter int OFF_SLOT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              hit,
    input  logic [SLOT_W-1:0] hit_slot,
    input  logic              toggle_mode,
    input  logic              btn_short,
    output logic              load_on
);
    logic load_q, load_nxt;

    always_comb begin
        load_nxt = load_q;
        if (done && hit) begin
            if (hit_slot == SLOT_W'(ON_SLOT)) begin
                load_nxt = toggle_mode ? ~load_q : 1'b1;
            end else if (hit_slot == SLOT_W'(OFF_SLOT)) begin
                load_nxt = 1'b0;
            end
        end
        if (btn_short) begin
            load_nxt = ~load_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b0;
        end else begin
            load_q <= load_nxt;
        end
    end

    assign load_on = load_q;
endmodule

// File: rtl/irm_seq.sv
`timescale 1ns/1ps
module irm_seq
    import irm_pkg::*;
#(
    parameter  int NSLOT     = 2,
    parameter  int MAX_PAIRS = 64,
    localparam int MAX_ELEM  = 2 * MAX_PAIRS,
    localparam int CAP_AW    = $clog2(4 * MAX_PAIRS),
    localparam int ELEM_W    = $clog2(MAX_ELEM),
    localparam int LEN_W     = $clog2(MAX_PAIRS + 1),
    localparam int SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int PAT_AW    = SLOT_W + CAP_AW,
    localparam int BYTE_CW   = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_req,
    input  logic              learn_req,
    input  logic [LEN_W-1:0]  cap_len,
    output logic [CAP_AW-1:0] cap_addr,
    input  logic [7:0]        cap_rdata,
    output logic [PAT_AW-1:0] pat_addr,
    output logic              pat_we,
    output logic [7:0]        pat_wdata,
    input  logic              lo_ok,
    input  elem_verdict_e     verdict,
    output logic              lo_ok_q,
    output logic              last_elem,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot
);
    seq_state_e          state;
    logic [SLOT_W-1:0]   slot;
    logic [SLOT_W-1:0]   lslot;
    logic                armed;
    logic [ELEM_W-1:0]   elem;
    logic [CAP_AW-1:0]   byte_idx;
    logic [BYTE_CW-1:0]  byte_last;
    logic                done_q, hit_q;
    logic [SLOT_W-1:0]   hslot_q;

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

    assign last_elem = (elem == ELEM_W'(MAX_ELEM - 1));

    always_comb begin
        cap_addr = (state == ST_CP_RD) ? byte_idx : CAP_AW'({elem, 1'b0});
        unique case (state)
            ST_RD_LO: pat_addr = {slot, CAP_AW'({elem, 1'b0})};
            ST_CP_WR: pat_addr = {lslot, byte_idx};
            default:  pat_addr = {slot, CAP_AW'({elem, 1'b1})};
        endcase
        pat_we    = (state == ST_CP_WR);
        pat_wdata = cap_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            slot      <= '0;
            lslot     <= '0;
            armed     <= 1'b0;
            elem      <= '0;
            lo_ok_q   <= 1'b0;
            byte_idx  <= '0;
            byte_last <= '0;
            done_q    <= 1'b0;
            hit_q     <= 1'b0;
            hslot_q   <= '0;
        end else begin
            done_q  <= 1'b0;
            hit_q   <= 1'b0;
            hslot_q <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (cmp_req && armed) begin
                        armed <= 1'b0;
                        if (cap_len != '0) begin
                            byte_idx  <= '0;
                            byte_last <= {cap_len, 2'b00} - BYTE_CW'(1);
                            state     <= ST_CP_RD;
                        end
                    end else begin
                        if (learn_req) begin
                            armed <= 1'b1;
                        end
                        if (cmp_req) begin
                            slot  <= '0;
                            elem  <= '0;
                            state <= ST_RD_LO;
                        end
                    end
                end
                ST_RD_LO: state <= ST_RD_HI;
                ST_RD_HI: begin
                    lo_ok_q <= lo_ok;
                    state   <= ST_EVAL;
                end
                ST_EVAL: begin
                    unique case (verdict)
                        EV_MATCH: begin
                            done_q  <= 1'b1;
                            hit_q   <= 1'b1;
                            hslot_q <= slot;
                            state   <= ST_IDLE;
                        end
                        EV_FAIL: begin
                            if (slot == LAST_SLOT) begin
                                done_q <= 1'b1;
                                state  <= ST_IDLE;
                            end else begin
                                slot  <= slot + SLOT_W'(1);
                                elem  <= '0;
                                state <= ST_RD_LO;
                            end
                        end
                        default: begin
                            elem  <= elem + ELEM_W'(1);
                            state <= ST_RD_LO;
                        end
                    endcase
                end
                ST_CP_RD: state <= ST_CP_WR;
                ST_CP_WR: begin
                    if (BYTE_CW'(byte_idx) == byte_last) begin
                        lslot <= (lslot == LAST_SLOT) ? '0 : lslot + SLOT_W'(1);
                        state <= ST_IDLE;
                    end else begin
                        byte_idx <= byte_idx + CAP_AW'(1);
                        state    <= ST_CP_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign hit      = hit_q;
    assign hit_slot = hslot_q;
endmodule

// File: rtl/irm_top.sv
`timescale 1ns/1ps
module irm_top
    import irm_pkg::*;
#(
    parameter  int         NSLOT     = 2,
    parameter  int         MAX_PAIRS = 64,
    parameter  int         TOL       = 4,
    parameter  logic [7:0] END_MARK  = 8'h02,
    localparam int         CAP_AW    = $clog2(4 * MAX_PAIRS),
    localparam int         LEN_W     = $clog2(MAX_PAIRS + 1),
    localparam int         SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int         PAT_AW    = SLOT_W + CAP_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_req,
    input  logic              learn_req,
    input  logic [LEN_W-1:0]  cap_len,
    input  logic              toggle_mode,
    input  logic              btn_short,
    output logic [CAP_AW-1:0] cap_addr,
    input  logic [7:0]        cap_rdata,
    output logic [PAT_AW-1:0] pat_addr,
    output logic              pat_we,
    output logic [7:0]        pat_wdata,
    input  logic [7:0]        pat_rdata,
    output logic              done,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic              load_on
);
    logic          lo_ok, lo_ok_q, last_elem;
    elem_verdict_e verdict;

    irm_tol_cmp #(.TOL(TOL)) u_tol (
        .stored (pat_rdata),
        .seen   (cap_rdata),
        .ok     (lo_ok)
    );

    irm_elem_judge #(.END_MARK(END_MARK), .ERASED_MARK(8'hFF)) u_judge (
        .hi_byte   (pat_rdata),
        .lo_ok     (lo_ok_q),
        .last_elem (last_elem),
        .verdict   (verdict)
    );

    irm_seq #(.NSLOT(NSLOT), .MAX_PAIRS(MAX_PAIRS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmp_req   (cmp_req),
        .learn_req (learn_req),
        .cap_len   (cap_len),
        .cap_addr  (cap_addr),
        .cap_rdata (cap_rdata),
        .pat_addr  (pat_addr),
        .pat_we    (pat_we),
        .pat_wdata (pat_wdata),
        .lo_ok     (lo_ok),
        .verdict   (verdict),
        .lo_ok_q   (lo_ok_q),
        .last_elem (last_elem),
        .done      (done),
        .hit       (hit),
        .hit_slot  (hit_slot)
    );

    irm_load_ctl #(.SLOT_W(SLOT_W), .ON_SLOT(0), .OFF_SLOT(1)) u_load (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .hit         (hit),
        .hit_slot    (hit_slot),
        .toggle_mode (toggle_mode),
        .btn_short   (btn_short),
        .load_on     (load_on)
    );
endmodule

// File: rtl/irm_chk.sv
`timescale 1ns/1ps
module irm_chk #(
    parameter int SLOT_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              hit,
    input logic [SLOT_W-1:0] hit_slot,
    input logic              toggle_mode,
    input logic              btn_short,
    input logic              pat_we,
    input logic              load_on
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R2
    hit_qual_chk: assert property (@(posedge clk) disable iff (rst) hit |-> done);
    // R2
    miss_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (hit_slot == '0));
    // R7
    slot0_on_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit && hit_slot == '0 && !toggle_mode && !btn_short) |=> load_on);
    // R7
    slot0_tog_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit && hit_slot == '0 && toggle_mode && !btn_short) |=> (load_on != $past(load_on)));
    // R7
    slot1_off_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit && hit_slot == SLOT_W'(1) && !btn_short) |=> !load_on);
    // R10
    btn_tog_chk: assert property (@(posedge clk) disable iff (rst)
        (btn_short && !done) |=> (load_on != $past(load_on)));
    // R7
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !btn_short) |=> $stable(load_on));
    // R8
    no_wr_at_result_chk: assert property (@(posedge clk) disable iff (rst) done |-> !pat_we);
endmodule

bind irm_top irm_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .hit         (hit),
    .hit_slot    (hit_slot),
    .toggle_mode (toggle_mode),
    .btn_short   (btn_short),
    .pat_we      (pat_we),
    .load_on     (load_on)
);

// File: tb/sim_irm_top.sv
`timescale 1ns/1ps
module sim_irm_top;
    localparam int NSLOT = 2;
    localparam int SB    = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_req = 1'b0, learn_req = 1'b0, toggle_mode = 1'b0, btn_short = 1'b0;
    logic [6:0] cap_len = '0;
    logic [7:0] cap_addr;
    logic [7:0] cap_rdata = '0;
    logic [8:0] pat_addr;
    logic       pat_we;
    logic [7:0] pat_wdata;
    logic [7:0] pat_rdata = '0;
    logic       done, hit, load_on;
    logic [0:0] hit_slot;

    always #2.5 clk = ~clk;

    irm_top u0 (
        .clk(clk), .rst(rst), .cmp_req(cmp_req), .learn_req(learn_req), .cap_len(cap_len),
        .toggle_mode(toggle_mode), .btn_short(btn_short), .cap_addr(cap_addr),
        .cap_rdata(cap_rdata), .pat_addr(pat_addr), .pat_we(pat_we), .pat_wdata(pat_wdata),
        .pat_rdata(pat_rdata), .done(done), .hit(hit), .hit_slot(hit_slot), .load_on(load_on)
    );

    logic [7:0] cap_mem [0:SB-1];
    logic [7:0] pat_mem [0:NSLOT*SB-1];

    always @(posedge clk) begin
        cap_rdata <= cap_mem[cap_addr];
        pat_rdata <= pat_mem[pat_addr];
        if (pat_we) pat_mem[pat_addr] <= pat_wdata;
    end

    int    cyc = 0;
    int    tests = 0, fails = 0, done_cnt = 0;
    int    exp_done_at = -1, exp_load_at = -1, exp_slot = 0, model_lslot = 0;
    bit    exp_hit = 0, exp_load_val = 0, model_load = 0, chk_on = 0;
    string cur_tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (chk_on) begin
            if (cyc == exp_load_at) model_load = exp_load_val;
            if (done) done_cnt++;
            check(done === (cyc == exp_done_at), {cur_tag, " R2 done timing"}, int'(done), int'(cyc == exp_done_at));
            if (cyc == exp_done_at) begin
                check(hit === exp_hit, {cur_tag, " hit flag"}, int'(hit), int'(exp_hit));
                check(int'(hit_slot) == exp_slot, {cur_tag, " hit slot"}, int'(hit_slot), exp_slot);
            end
            check(load_on === model_load, {cur_tag, " R7/R10 load level"}, int'(load_on), int'(model_load));
        end
    end

    function automatic int base_lo(input int kind, input int e);
        if (kind == 0) begin
            if (e == 0) return 8'h90;
            if (e == 1) return 8'h47;
            if (e == 3) return 8'h02;
            if (e % 2 == 0) return 8'h08;
            return (e % 4 == 1) ? 8'h1a : 8'h07;
        end
        if (e == 0) return 8'h90;
        if (e == 1) return 8'h23;
        if (e % 2 == 0) return 8'h09;
        return (e % 4 == 3) ? 8'h1a : 8'h08;
    endfunction

    // 12-element packet (6 pairs); element 11 is the timeout space (high byte 2)
    task automatic load_cap(input int kind, input int delta, input bit junk_hi);
        for (int e = 0; e < SB / 2; e++) begin
            if (e < 11) begin
                cap_mem[2*e]   = 8'((base_lo(kind, e) + delta + 256) % 256);
                cap_mem[2*e+1] = junk_hi ? 8'h33 : 8'h00;
            end else if (e == 11) begin
                cap_mem[2*e]   = 8'h00;
                cap_mem[2*e+1] = 8'h02;
            end else begin
                cap_mem[2*e]   = 8'h55;
                cap_mem[2*e+1] = 8'h00;
            end
        end
    endtask

    function automatic void scan(input int s, output bit m, output int n);
        m = 0;
        n = 0;
        for (int e = 0; e < 128; e++) begin
            int lo_s, lo_c, hi, d;
            lo_s = int'(pat_mem[s*SB + 2*e]);
            lo_c = int'(cap_mem[2*e]);
            hi   = int'(pat_mem[s*SB + 2*e + 1]);
            n = e + 1;
            if (hi == 255) return;
            if (hi == 2) begin
                m = 1;
                return;
            end
            d = (lo_s - lo_c + 256) % 256;
            if (!(d <= 4 || d >= 252)) return;
        end
    endfunction

    task automatic do_cmp(input string tag, input int extra_at);
        bit m, hv, nl;
        int n, tot, hs;
        hv = 0; hs = 0; tot = 0;
        cur_tag = tag;
        for (int s = 0; s < NSLOT; s++) begin
            scan(s, m, n);
            tot += n;
            if (m) begin
                hv = 1;
                hs = s;
                break;
            end
        end
        nl = model_load;
        if (hv && hs == 0) nl = toggle_mode ? !model_load : 1'b1;
        else if (hv && hs == 1) nl = 1'b0;
        exp_hit      = hv;
        exp_slot     = hv ? hs : 0;
        exp_done_at  = cyc + 1 + 3 * tot;
        exp_load_at  = exp_done_at + 1;
        exp_load_val = nl;
        cmp_req = 1'b1;
        @(negedge clk);
        cmp_req = 1'b0;
        if (extra_at >= 0) begin
            repeat (extra_at) @(negedge clk);
            cmp_req = 1'b1;
            @(negedge clk);
            cmp_req = 1'b0;
        end
        while (cyc <= exp_load_at + 1) @(negedge clk);
    endtask

    task automatic do_learn(input int len, input string tag);
        bit ok;
        cur_tag = tag;
        learn_req = 1'b1;
        @(negedge clk);
        learn_req = 1'b0;
        cap_len = 7'(len);
        cmp_req = 1'b1;
        @(negedge clk);
        cmp_req = 1'b0;
        repeat (8 * len + 4) @(negedge clk);
        ok = 1;
        for (int i = 0; i < 4 * len; i++)
            if (pat_mem[model_lslot*SB + i] !== cap_mem[i]) ok = 0;
        check(ok, {tag, " R8 copied bytes in learn slot"}, int'(ok), 1);
        if (len > 0) model_lslot = (model_lslot + 1) % NSLOT;
    endtask

    task automatic press_btn();
        cur_tag = "R10";
        exp_load_at  = cyc + 1;
        exp_load_val = !model_load;
        btn_short = 1'b1;
        @(negedge clk);
        btn_short = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] snap [0:15];
        int d0;
        bit ok;
        for (int i = 0; i < SB; i++) cap_mem[i] = 8'h00;
        for (int i = 0; i < NSLOT*SB; i++) pat_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done === 1'b0, "R1 done after reset", int'(done), 0);
        check(hit === 1'b0, "R1 hit after reset", int'(hit), 0);
        check(load_on === 1'b0, "R1 load after reset", int'(load_on), 0);
        check(pat_we === 1'b0, "R1 no write after reset", int'(pat_we), 0);
        chk_on = 1;

        load_cap(0, 0, 0); do_learn(6, "R8 learn A slot0");
        load_cap(1, 0, 0); do_learn(6, "R8 learn B slot1");

        load_cap(0, 0, 0); do_cmp("R2 exact A", -1);
        load_cap(1, 0, 0); do_cmp("R2 B after slot0 miss", -1);
        load_cap(0, 4, 0); do_cmp("R3 +4 ticks", -1);
        load_cap(0, -4, 0); do_cmp("R3 -4 ticks with wrap", -1);
        load_cap(0, 0, 1); do_cmp("R3 captured high bytes ignored", -1);
        load_cap(0, 0, 0); cap_mem[22] = 8'h77; do_cmp("R4 end element low ignored", -1);
        load_cap(0, 5, 0); do_cmp("R3 +5 ticks rejected", -1);

        toggle_mode = 1'b1;
        load_cap(0, 0, 0); do_cmp("R7 toggle off", -1);
        load_cap(0, 0, 0); do_cmp("R7 toggle on", -1);
        toggle_mode = 1'b0;
        press_btn();

        // R9 empty learn: nothing written, learn slot kept
        load_cap(1, 0, 0);
        for (int i = 0; i < 16; i++) snap[i] = pat_mem[model_lslot*SB + i];
        d0 = done_cnt;
        do_learn(0, "R9 empty packet");
        ok = 1;
        for (int i = 0; i < 16; i++) if (pat_mem[model_lslot*SB + i] !== snap[i]) ok = 0;
        check(ok, "R9 store unchanged", int'(ok), 1);
        check(done_cnt == d0, "R9 no done on empty learn", done_cnt - d0, 0);
        do_cmp("R9 disarmed compare", -1);

        load_cap(1, 0, 0); do_learn(6, "R8 wrap to slot0");
        do_cmp("R2 first match wins", -1);

        d0 = done_cnt;
        do_cmp("R11 busy request", 3);
        check(done_cnt - d0 == 1, "R11 single result", done_cnt - d0, 1);

        pat_mem[1] = 8'hFF;
        do_cmp("R5 erased slot0", -1);

        for (int e = 0; e < 128; e++) begin
            pat_mem[2*e] = 8'h10; pat_mem[2*e+1] = 8'h00;
            cap_mem[2*e] = 8'h10; cap_mem[2*e+1] = 8'h00;
        end
        do_cmp("R6 128 element limit", -1);
        pat_mem[255] = 8'h02;
        do_cmp("R4 end marker at last element", -1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule